// File: doc/BRIEF.md
# Hashed Page Table Index Generator

This block turns an effective address into the values needed to look up a hashed page table. Each request carries a 64-bit effective address, a virtual segment identifier, a segment-size code, the page-size shift and the table's group mask. From these the block builds the virtual address, hashes it, and produces two entry indices: one for the primary group and one for the secondary group. The virtual address and hash are delivered alongside the indices.

The request side and the result side are valid/ready streams separated by a single register stage. A request is taken on any clock edge where `in_valid` and `in_ready` are both high. A result stays on the outputs, unchanged, until the edge where `out_valid` and `out_ready` are both high. `in_ready` is high whenever the result register is empty or is being emptied in the same cycle. Back-pressure therefore reaches the request side in the same cycle, with no skid storage. When `out_ready` stays high, the block takes one request per cycle.

Two segment sizes are supported. Code 0 selects 256 MB segments and code 1 selects 1 TB segments. Codes 2 and 3 are reserved. A request carrying a reserved code is still consumed, but it yields no result. Instead it raises a one-cycle error pulse, which is a plain status pin outside the stream.

Top module: `hpt_index_gen`

## Requirements
- R1: With segment code 0, `out_va` equals the VSID placed at bit 28 and up, ORed with effective-address bits [27:0], truncated to 64 bits.
- R2: With segment code 1, `out_va` equals the VSID placed at bit 40 and up, ORed with effective-address bits [39:0], truncated to 64 bits.
- R3: With segment code 0, `out_hash` equals (VA shifted right by 28) XOR (VA[27:0] shifted right by the page shift).
- R4: With segment code 1, with s = VA shifted right by 40, `out_hash` equals s XOR (s shifted left by 25) XOR (VA[39:0] shifted right by the page shift).
- R5: `out_hash` keeps only the low 39 bits of the hash. Any term above bit 38 is discarded.
- R6: `out_pidx` is (hash AND mask) times 8, so a group's eight entries start at that index. Bits [2:0] of the index are zero.
- R7: `out_sidx` is ((NOT hash) AND mask) times 8.
- R8: A request taken with segment code 2 or 3 sets `out_err` high for exactly the next cycle. It produces no `out_valid` for that request.
- R9: A request taken with code 0 or 1 appears on the outputs with `out_valid` high in the next cycle. Back-to-back requests are taken one per cycle while `out_ready` is high.
- R10: While `out_valid` is high and `out_ready` is low, all result outputs hold their values and `in_ready` is low. A request offered then is not taken.
- R11: After reset, `out_valid` and `out_err` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block can take a request this cycle |
| in_ea | input | 64 | Effective address |
| in_vsid | input | VSID_W (36) | Virtual segment identifier |
| in_ssize | input | 2 | Segment-size code: 0 = 256 MB, 1 = 1 TB, 2/3 reserved |
| in_pshift | input | PSHIFT_W (6) | Page-size shift amount |
| in_mask | input | HASH_W (39) | Table group mask |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_va | output | 64 | Virtual address |
| out_hash | output | HASH_W (39) | Truncated hash |
| out_pidx | output | HASH_W+3 (42) | First entry index of the primary group |
| out_sidx | output | HASH_W+3 (42) | First entry index of the secondary group |
| out_err | output | 1 | One-cycle pulse for a taken request with a reserved segment code |

## Verification
The hardest condition to reach from the ports is a new request offered while a stalled result is being held. The block must refuse the new request without disturbing the held result, and then accept it on the exact cycle the stall ends. The bench drops `out_ready` right after issuing a request and presents a second request with different operands during the stall. It checks that the held outputs are unchanged, then raises `out_ready` and checks that the second request emerges one cycle later. Truncation of the 1 TB fold is driven by a VSID bit that shifts exactly to bit 39.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
  localparam int VA_W        = 64;
  localparam int SHORT_SEG_W = 28;
  localparam int LONG_SEG_W  = 40;
  localparam int FOLD_SHL    = 25;

  typedef enum logic [1:0] {
    SEG_256M = 2'd0,
    SEG_1T   = 2'd1,
    SEG_RSV2 = 2'd2,
    SEG_RSV3 = 2'd3
  } seg_code_e;
endpackage

// File: rtl/hpt_va_form.sv
module hpt_va_form
  import hpt_pkg::*;
#(
  parameter int VSID_W = 36
) (
  input  logic [VA_W-1:0]   ea,
  input  logic [VSID_W-1:0] vsid,
  input  logic              seg_long,
  output logic [VA_W-1:0]   va
);
  localparam int PAD_W = VA_W - VSID_W;

  logic [VA_W-1:0] vsid_ext;
  logic [VA_W-1:0] short_va;
  logic [VA_W-1:0] long_va;

  assign vsid_ext = {{PAD_W{1'b0}}, vsid};
  assign short_va = (vsid_ext << SHORT_SEG_W)
                  | {{(VA_W-SHORT_SEG_W){1'b0}}, ea[SHORT_SEG_W-1:0]};
  assign long_va  = (vsid_ext << LONG_SEG_W)
                  | {{(VA_W-LONG_SEG_W){1'b0}}, ea[LONG_SEG_W-1:0]};
  assign va = seg_long ? long_va : short_va;
endmodule

// File: rtl/hpt_hash_calc.sv
module hpt_hash_calc
  import hpt_pkg::*;
#(
  parameter int HASH_W   = 39,
  parameter int PSHIFT_W = 6
) (
  input  logic [VA_W-1:0]     va,
  input  logic                seg_long,
  input  logic [PSHIFT_W-1:0] pshift,
  output logic [HASH_W-1:0]   hash
);
  logic [VA_W-1:0] seg_s;
  logic [VA_W-1:0] off_s;
  logic [VA_W-1:0] full_s;
  logic [VA_W-1:0] seg_l;
  logic [VA_W-1:0] off_l;
  logic [VA_W-1:0] full_l;

  // short segments: segment number against in-segment page number
  assign seg_s  = va >> SHORT_SEG_W;
  assign off_s  = {{(VA_W-SHORT_SEG_W){1'b0}}, va[SHORT_SEG_W-1:0]} >> pshift;
  assign full_s = seg_s ^ off_s;

  // long segments: segment number is folded onto itself before mixing
  assign seg_l  = va >> LONG_SEG_W;
  assign off_l  = {{(VA_W-LONG_SEG_W){1'b0}}, va[LONG_SEG_W-1:0]} >> pshift;
  assign full_l = seg_l ^ (seg_l << FOLD_SHL) ^ off_l;

  assign hash = seg_long ? full_l[HASH_W-1:0] : full_s[HASH_W-1:0];
endmodule

// File: rtl/hpt_group_idx.sv
module hpt_group_idx #(
  parameter int HASH_W     = 39,
  parameter int GRP_ENTRY  = 8,
  parameter bit INVERT     = 1'b0,
  localparam int GRP_SH    = $clog2(GRP_ENTRY),
  localparam int IDX_W     = HASH_W + GRP_SH
) (
  input  logic [HASH_W-1:0] hash,
  input  logic [HASH_W-1:0] mask,
  output logic [IDX_W-1:0]  idx
);
  logic [HASH_W-1:0] sel;
  logic [HASH_W-1:0] grp;

  generate
    if (INVERT) begin : g_alt
      assign sel = ~hash;
    end else begin : g_main
      assign sel = hash;
    end
  endgenerate

  assign grp = sel & mask;
  assign idx = {grp, {GRP_SH{1'b0}}};
endmodule

// File: rtl/hpt_index_gen.sv
module hpt_index_gen
  import hpt_pkg::*;
#(
  parameter int VSID_W    = 36,
  parameter int HASH_W    = 39,
  parameter int PSHIFT_W  = 6,
  parameter int GRP_ENTRY = 8,
  localparam int IDX_W    = HASH_W + $clog2(GRP_ENTRY)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [VA_W-1:0]     in_ea,
  input  logic [VSID_W-1:0]   in_vsid,
  input  logic [1:0]          in_ssize,
  input  logic [PSHIFT_W-1:0] in_pshift,
  input  logic [HASH_W-1:0]   in_mask,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [VA_W-1:0]     out_va,
  output logic [HASH_W-1:0]   out_hash,
  output logic [IDX_W-1:0]    out_pidx,
  output logic [IDX_W-1:0]    out_sidx,
  output logic                out_err
);
  seg_code_e         code;
  logic              seg_long;
  logic              reserved;
  logic              take;
  logic              load;
  logic [VA_W-1:0]   va_c;
  logic [HASH_W-1:0] hash_c;
  logic [IDX_W-1:0]  idx_c [2];

  logic              valid_q;
  logic              err_q;
  logic [VA_W-1:0]   va_q;
  logic [HASH_W-1:0] hash_q;
  logic [IDX_W-1:0]  pidx_q;
  logic [IDX_W-1:0]  sidx_q;

  assign code     = seg_code_e'(in_ssize);
  assign seg_long = (code == SEG_1T);
  assign reserved = (code == SEG_RSV2) || (code == SEG_RSV3);

  assign in_ready = !valid_q || out_ready;
  assign take     = in_valid && in_ready;
  assign load     = take && !reserved;

  hpt_va_form #(.VSID_W(VSID_W)) u_va (
    .ea       (in_ea),
    .vsid     (in_vsid),
    .seg_long (seg_long),
    .va       (va_c)
  );

  hpt_hash_calc #(.HASH_W(HASH_W), .PSHIFT_W(PSHIFT_W)) u_hash (
    .va       (va_c),
    .seg_long (seg_long),
    .pshift   (in_pshift),
    .hash     (hash_c)
  );

  generate
    for (genvar gi = 0; gi < 2; gi++) begin : g_grp
      hpt_group_idx #(
        .HASH_W    (HASH_W),
        .GRP_ENTRY (GRP_ENTRY),
        .INVERT    (gi == 1)
      ) u_idx (
        .hash (hash_c),
        .mask (in_mask),
        .idx  (idx_c[gi])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      err_q <= take && reserved;
      if (in_ready) valid_q <= load;
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      va_q   <= va_c;
      hash_q <= hash_c;
      pidx_q <= idx_c[0];
      sidx_q <= idx_c[1];
    end
  end

  assign out_valid = valid_q;
  assign out_err   = err_q;
  assign out_va    = va_q;
  assign out_hash  = hash_q;
  assign out_pidx  = pidx_q;
  assign out_sidx  = sidx_q;
endmodule

// File: rtl/hpt_index_gen_chk.sv
module hpt_index_gen_chk #(
  parameter int HASH_W = 39,
  parameter int IDX_W  = 42
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [1:0]        in_ssize,
  input logic              out_valid,
  input logic              out_ready,
  input logic [63:0]       out_va,
  input logic [HASH_W-1:0] out_hash,
  input logic [IDX_W-1:0]  out_pidx,
  input logic [IDX_W-1:0]  out_sidx,
  input logic              out_err
);
  localparam int GS = IDX_W - HASH_W;

  logic [HASH_W-1:0] pg;
  logic [HASH_W-1:0] sg;
  assign pg = out_pidx[IDX_W-1:GS];
  assign sg = out_sidx[IDX_W-1:GS];

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_hash) &&
                                   $stable(out_va) && $stable(out_pidx)));

  a_r10_stall_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !in_ssize[1]) |=> out_valid);

  a_r8_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_ssize[1]) |=> (out_err && !out_valid));

  a_r8_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_err |=> !out_err || $past(in_valid && in_ready && in_ssize[1]));

  // R6 / R7: groups are disjoint and the primary one is the hash under their union
  a_r7_groups: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((pg & sg) == '0 && pg == (out_hash & (pg | sg)) &&
                   out_pidx[GS-1:0] == '0 && out_sidx[GS-1:0] == '0));
endmodule

bind hpt_index_gen hpt_index_gen_chk #(.HASH_W(HASH_W), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_ssize  (in_ssize),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_va    (out_va),
  .out_hash  (out_hash),
  .out_pidx  (out_pidx),
  .out_sidx  (out_sidx),
  .out_err   (out_err)
);

// File: tb/hpt_index_gen_test.sv
module hpt_index_gen_test;
  localparam int NV = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_ea = '0;
  logic [35:0] in_vsid = '0;
  logic [1:0]  in_ssize = '0;
  logic [5:0]  in_pshift = '0;
  logic [38:0] in_mask = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_va;
  logic [38:0] out_hash;
  logic [41:0] out_pidx;
  logic [41:0] out_sidx;
  logic        out_err;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  hpt_index_gen uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_ea(in_ea), .in_vsid(in_vsid), .in_ssize(in_ssize),
    .in_pshift(in_pshift), .in_mask(in_mask), .out_valid(out_valid),
    .out_ready(out_ready), .out_va(out_va), .out_hash(out_hash),
    .out_pidx(out_pidx), .out_sidx(out_sidx), .out_err(out_err)
  );

  localparam logic [63:0] T_EA [NV] = '{
    64'h0000_0000_0000_3000, 64'hC000_0000_0ABC_D123, 64'h0000_00F1_2345_6789,
    64'h1234_5678_9ABC_DEF0, 64'h0000_0000_0FFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF,
    64'h0000_0012_3400_0000, 64'h0000_0000_0001_0000};
  localparam logic [35:0] T_VSID [NV] = '{
    36'h5, 36'hF_FFFF_FFFF, 36'h0_00AB_CDEF, 36'h1_2345_6789,
    36'h0, 36'hA_5A5A_5A5A, 36'h0_0000_4001, 36'h8_0000_0001};
  localparam logic [1:0] T_SS [NV] = '{2'd0, 2'd0, 2'd1, 2'd1, 2'd0, 2'd1, 2'd1, 2'd0};
  localparam logic [5:0] T_PS [NV] = '{6'd12, 6'd16, 6'd12, 6'd24, 6'd12, 6'd16, 6'd20, 6'd24};
  localparam logic [38:0] T_MASK [NV] = '{
    39'hFF, 39'hFFFF, 39'h7F_FFFF_FFFF, 39'h3FF,
    39'h0, 39'h7F_FFFF_FFFF, 39'hF_FFFF, 39'h1};

  function automatic logic [63:0] ref_va(logic [63:0] ea, logic [35:0] vs, logic [1:0] ss);
    logic [63:0] v = {28'b0, vs};
    if (ss == 2'd0) return (v << 28) | {36'b0, ea[27:0]};
    return (v << 40) | {24'b0, ea[39:0]};
  endfunction

  function automatic logic [38:0] ref_hash(logic [63:0] va, logic [5:0] ps, logic [1:0] ss);
    logic [63:0] s;
    logic [63:0] h;
    if (ss == 2'd0) begin
      h = (va >> 28) ^ ({36'b0, va[27:0]} >> ps);
    end else begin
      s = va >> 40;
      h = s ^ (s << 25) ^ ({24'b0, va[39:0]} >> ps);
    end
    return h[38:0];
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [63:0] ea, input logic [35:0] vs, input logic [1:0] ss,
                       input logic [5:0] ps, input logic [38:0] mk);
    in_valid = 1'b1; in_ea = ea; in_vsid = vs; in_ssize = ss; in_pshift = ps; in_mask = mk;
  endtask

  task automatic check_result(input logic [63:0] ea, input logic [35:0] vs, input logic [1:0] ss,
                              input logic [5:0] ps, input logic [38:0] mk, input string tag);
    logic [63:0] va = ref_va(ea, vs, ss);
    logic [38:0] h  = ref_hash(va, ps, ss);
    logic [41:0] pi = {h & mk, 3'b000};
    logic [41:0] si = {~h & mk, 3'b000};
    chk(out_valid === 1'b1, {tag, " R9 valid"}, {63'b0, out_valid}, 64'd1);
    chk(out_va === va, (ss == 0) ? {tag, " R1 va"} : {tag, " R2 va"}, out_va, va);
    chk(out_hash === h, (ss == 0) ? {tag, " R3 hash"} : {tag, " R4 hash"},
        {25'b0, out_hash}, {25'b0, h});
    chk(out_pidx === pi, {tag, " R6 pidx"}, {22'b0, out_pidx}, {22'b0, pi});
    chk(out_sidx === si, {tag, " R7 sidx"}, {22'b0, out_sidx}, {22'b0, si});
  endtask

  initial begin
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R11: reset state
    #12;
    chk(out_valid === 1'b0, "R11 out_valid", {63'b0, out_valid}, 64'd0);
    chk(out_err === 1'b0, "R11 out_err", {63'b0, out_err}, 64'd0);
    chk(in_ready === 1'b1, "R11 in_ready", {63'b0, in_ready}, 64'd1);
    @(negedge clk); rst_n = 1'b1;

    // table walk, one request per cycle (R9 throughput)
    for (int i = 0; i <= NV; i++) begin
      @(negedge clk);
      if (i > 0) check_result(T_EA[i-1], T_VSID[i-1], T_SS[i-1], T_PS[i-1], T_MASK[i-1], "table");
      if (i < NV) drive(T_EA[i], T_VSID[i], T_SS[i], T_PS[i], T_MASK[i]);
      else in_valid = 1'b0;
    end
    @(negedge clk);
    chk(out_valid === 1'b0, "R9 idle", {63'b0, out_valid}, 64'd0);

    // hand-derived: 256M, vsid 5, page 3 -> hash 6
    drive(64'h3000, 36'h5, 2'd0, 6'd12, 39'hFF);
    @(negedge clk); in_valid = 1'b0;
    chk(out_hash === 39'h6, "R3 hand hash", {25'b0, out_hash}, 64'h6);
    chk(out_pidx === 42'h30, "R6 hand pidx", {22'b0, out_pidx}, 64'h30);
    chk(out_sidx === 42'h7C8, "R7 hand sidx", {22'b0, out_sidx}, 64'h7C8);

    // hand-derived: 1T fold, vsid 1 -> 0x2000001
    drive(64'h0, 36'h1, 2'd1, 6'd12, 39'h0);
    @(negedge clk); in_valid = 1'b0;
    chk(out_va === 64'h100_0000_0000, "R2 hand va", out_va, 64'h100_0000_0000);
    chk(out_hash === 39'h200_0001, "R4 hand hash", {25'b0, out_hash}, 64'h200_0001);

    // R5: fold term lands on bit 39 and is dropped
    drive(64'h0, 36'h4000, 2'd1, 6'd12, 39'h0);
    @(negedge clk); in_valid = 1'b0;
    chk(out_hash === 39'h4000, "R5 truncation", {25'b0, out_hash}, 64'h4000);

    // R8: reserved codes
    drive(64'h1234, 36'h7, 2'd2, 6'd12, 39'hFF);
    @(negedge clk);
    drive(64'h1234, 36'h7, 2'd3, 6'd12, 39'hFF);
    chk(out_err === 1'b1, "R8 err code2", {63'b0, out_err}, 64'd1);
    chk(out_valid === 1'b0, "R8 no valid code2", {63'b0, out_valid}, 64'd0);
    @(negedge clk); in_valid = 1'b0;
    chk(out_err === 1'b1, "R8 err code3", {63'b0, out_err}, 64'd1);
    chk(out_valid === 1'b0, "R8 no valid code3", {63'b0, out_valid}, 64'd0);
    @(negedge clk);
    chk(out_err === 1'b0, "R8 pulse ends", {63'b0, out_err}, 64'd0);

    // R10: stall holds A, refuses B, then B follows
    out_ready = 1'b0;
    drive(T_EA[2], T_VSID[2], T_SS[2], T_PS[2], T_MASK[2]);
    @(negedge clk);
    drive(T_EA[3], T_VSID[3], T_SS[3], T_PS[3], T_MASK[3]);
    chk(in_ready === 1'b0, "R10 in_ready low", {63'b0, in_ready}, 64'd0);
    @(negedge clk);
    @(negedge clk);
    check_result(T_EA[2], T_VSID[2], T_SS[2], T_PS[2], T_MASK[2], "R10 held");
    out_ready = 1'b1;
    @(negedge clk); in_valid = 1'b0;
    check_result(T_EA[3], T_VSID[3], T_SS[3], T_PS[3], T_MASK[3], "R10 after stall");
    @(negedge clk);
    chk(out_valid === 1'b0, "R10 single accept", {63'b0, out_valid}, 64'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule